// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with a compact register set on a simple synchronous write/read bus. Software programs a timer value, restarts the countdown through a reload register, and starts or stops it with a halt bit in the control register. While running, the counter steps down by one on each cycle that a slow tick enable is high.

The first expiry marks a timeout status bit, optionally raises a one-cycle management interrupt request, and restarts the count. If the counter runs out a second time with no service in between, the block flags a second-timeout status, emits a one-cycle system reset pulse unless a no-reboot control bit is set, and halts. Service means a reload write or a clear of the timeout status.

The second-timeout and boot status bits sit in a separate power-on reset domain. They survive the system reset that the block itself may cause, so software can report a watchdog-caused restart after boot.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the timer-value register reads 4, the count reads 4, the control register reads 0x0800 (halt set), configuration and status registers read 0, and both pulse outputs are low.
- R2: A write to the timer-value register (offset 0) stores the low 10-bit field (6-bit in the narrow variant, whose bits 7:6 are stored as written). A field value below 2 is stored as 2.
- R3: In the control register (offset 2), bit 11 is halt and bit 9 is a general bit kept as written. Every other bit reads back 0 whatever was written.
- R4: While halt is 0, each tick-enable cycle lowers the count (read at offset 1) by one. While halt is 1, ticks leave the count unchanged.
- R5: A write to offset 1 with any of data bits 4:0 set loads the count from the timer-value register. A write with bits 4:0 all zero has no effect.
- R6: The expiry occurs on the tick that arrives while the count is 0. If no expiry is pending, it sets status bit 3 at offset 3 and reloads the count. With configuration bit 0 (interrupt enable) set, it also drives smi_req high for exactly one cycle.
- R7: With interrupt enable cleared, a first expiry still sets the timeout status and smi_req stays low.
- R8: A second expiry without intervening service sets status bit 1 at offset 4, drives sys_rst high for exactly one cycle, and sets halt. Later ticks then leave the count unchanged.
- R9: While configuration bit 1 (no-reboot) is set, a second expiry leaves sys_rst low but still records the second-timeout status.
- R10: While nr_lock is high, the no-reboot bit reads 1 and a written 0 does not clear it. It stays 1 after the lock drops until software writes 0.
- R11: Status bits are write-1-to-clear. A write clears exactly the status bits written as 1 and leaves the rest unchanged. Writing 0 changes nothing.
- R12: The second-timeout bit and the boot bit (bit 2 at offset 4) keep their value through rst_n and are cleared only by por_n or a write of 1. A second expiry while the second-timeout bit is already set also sets the boot bit.
- R13: A reload write, or a write-1 clear of the timeout status, between two expiries makes the next expiry a first expiry again, with no reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| por_n | input | 1 | Asynchronous active-low power-on reset, also clears sticky status |
| tick_en | input | 1 | Slow countdown enable, one cycle per tick |
| nr_lock | input | 1 | Forces the no-reboot bit to 1 while high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| smi_req | output | 1 | One-cycle management interrupt request on first expiry |
| sys_rst | output | 1 | One-cycle system reset pulse on second expiry |

## Verification
The countdown is driven with ticks while running and while halted, and with reload writes that have bits 4:0 set and clear. This separates real reloads from ignored writes and tick-driven motion from a frozen count. The expiry path is run as an unserviced pair, as a pair with no-reboot set, and as expiries separated by a reload or by a status clear. This tells apart the first-stage action, the reset action and its suppression. Status writes that set one bit at a time show that the write-1-to-clear bits are isolated from each other, and resets applied separately through rst_n and por_n show which domain holds the sticky bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 16;
  localparam int AW = 3;

  // register offsets
  localparam logic [AW-1:0] A_TMR  = 3'd0;
  localparam logic [AW-1:0] A_CNT  = 3'd1;
  localparam logic [AW-1:0] A_CTRL = 3'd2;
  localparam logic [AW-1:0] A_STS1 = 3'd3;
  localparam logic [AW-1:0] A_STS2 = 3'd4;
  localparam logic [AW-1:0] A_CFG  = 3'd5;

  // bit positions
  localparam int CTRL_HALT = 11;
  localparam int CTRL_KEEP = 9;
  localparam int STS1_TO   = 3;
  localparam int STS2_SEC  = 1;
  localparam int STS2_BOOT = 2;
  localparam int CFG_SMI   = 0;
  localparam int CFG_NR    = 1;
  localparam int RLD_BITS  = 5;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter bit WIDE    = 1'b1,
  parameter int TW      = 10,
  parameter int MIN_CNT = 2,
  parameter int RST_TMR = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [TW-1:0] cnt_i,
  input  logic          first_exp,
  input  logic          second_exp,
  input  logic          nr_lock,
  output logic [TW-1:0] tmr_o,
  output logic          halt_o,
  output logic          smi_en_o,
  output logic          nr_o,
  output logic          reload_o,
  output logic          to_clr_o
);
  logic wr_tmr, wr_cnt, wr_ctrl, wr_sts1, wr_sts2, wr_cfg;
  logic [TW-1:0] wr_field, clamped;

  logic [TW-1:0] tmr_q, tmr_d;
  logic halt_q, halt_d, keep_q, keep_d, smi_q, smi_d, nr_q, nr_d, to_q, to_d;
  logic sec_q, sec_d, boot_q, boot_d;
  logic [DW-1:0] tmr_rd;

  assign wr_tmr  = we && (addr == A_TMR);
  assign wr_cnt  = we && (addr == A_CNT);
  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_sts1 = we && (addr == A_STS1);
  assign wr_sts2 = we && (addr == A_STS2);
  assign wr_cfg  = we && (addr == A_CFG);

  assign wr_field = wdata[TW-1:0];
  assign clamped  = (wr_field < TW'(MIN_CNT)) ? TW'(MIN_CNT) : wr_field;

  assign reload_o = wr_cnt && (|wdata[RLD_BITS-1:0]);
  assign to_clr_o = wr_sts1 && wdata[STS1_TO];

  // next state
  always_comb begin
    tmr_d  = tmr_q;
    halt_d = halt_q;
    keep_d = keep_q;
    smi_d  = smi_q;
    nr_d   = nr_q;
    to_d   = to_q;
    sec_d  = sec_q;
    boot_d = boot_q;
    if (wr_tmr) tmr_d = clamped;
    if (wr_ctrl) begin
      halt_d = wdata[CTRL_HALT];
      keep_d = wdata[CTRL_KEEP];
    end
    if (second_exp) halt_d = 1'b1;
    if (wr_cfg) begin
      smi_d = wdata[CFG_SMI];
      nr_d  = wdata[CFG_NR];
    end
    if (nr_lock) nr_d = 1'b1;
    if (to_clr_o) to_d = 1'b0;
    if (first_exp) to_d = 1'b1;
    if (wr_sts2 && wdata[STS2_SEC])  sec_d  = 1'b0;
    if (wr_sts2 && wdata[STS2_BOOT]) boot_d = 1'b0;
    if (second_exp) begin
      if (sec_q) boot_d = 1'b1;
      sec_d = 1'b1;
    end
  end

  // system-reset domain
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= TW'(RST_TMR);
      halt_q <= 1'b1;
      keep_q <= 1'b0;
      smi_q  <= 1'b0;
      nr_q   <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      halt_q <= halt_d;
      keep_q <= keep_d;
      smi_q  <= smi_d;
      nr_q   <= nr_d;
      to_q   <= to_d;
    end
  end

  // power-on domain: sticky status
  always_ff @(posedge clk or negedge por_ni) begin
    if (!por_ni) begin
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      boot_q <= boot_d;
    end
  end

  generate
    if (WIDE) begin : g_wide
      always_comb begin
        tmr_rd = '0;
        tmr_rd[TW-1:0] = tmr_q;
      end
    end else begin : g_narrow
      logic [1:0] hi_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)     hi_q <= '0;
        else if (wr_tmr) hi_q <= wdata[TW+1:TW];
      end
      always_comb begin
        tmr_rd = '0;
        tmr_rd[TW+1:0] = {hi_q, tmr_q};
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (addr)
      A_TMR:  rdata = tmr_rd;
      A_CNT:  rdata[TW-1:0] = cnt_i;
      A_CTRL: begin
        rdata[CTRL_HALT] = halt_q;
        rdata[CTRL_KEEP] = keep_q;
      end
      A_STS1: rdata[STS1_TO] = to_q;
      A_STS2: begin
        rdata[STS2_SEC]  = sec_q;
        rdata[STS2_BOOT] = boot_q;
      end
      A_CFG: begin
        rdata[CFG_SMI] = smi_q;
        rdata[CFG_NR]  = nr_q;
      end
      default: rdata = '0;
    endcase
  end

  assign tmr_o    = tmr_q;
  assign halt_o   = halt_q;
  assign smi_en_o = smi_q;
  assign nr_o     = nr_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int TW      = 10,
  parameter int RST_TMR = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          tick,
  input  logic          halt,
  input  logic [TW-1:0] tmr,
  input  logic          reload,
  input  logic          stage_clr,
  input  logic          smi_en,
  input  logic          no_reboot,
  output logic [TW-1:0] cnt_o,
  output logic          first_exp,
  output logic          second_exp,
  output logic          smi_req,
  output logic          sys_rst
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic stage_q, stage_d, smi_q, smi_d, rst_q, rst_d;
  logic step, expire;

  assign step       = tick && !halt && !reload;
  assign expire     = step && (cnt_q == '0);
  assign first_exp  = expire && !stage_q;
  assign second_exp = expire && stage_q;

  always_comb begin
    cnt_d   = cnt_q;
    stage_d = stage_q;
    if (reload)         cnt_d = tmr;
    else if (expire)    cnt_d = tmr;
    else if (step)      cnt_d = cnt_q - 1'b1;
    if (reload || stage_clr) stage_d = 1'b0;
    if (first_exp)           stage_d = 1'b1;
    if (second_exp)          stage_d = 1'b0;
    smi_d = first_exp && smi_en;
    rst_d = second_exp && !no_reboot;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= TW'(RST_TMR);
      stage_q <= 1'b0;
      smi_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
      smi_q   <= smi_d;
      rst_q   <= rst_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign smi_req = smi_q;
  assign sys_rst = rst_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter bit WIDE      = 1'b1,
  parameter int MIN_CNT   = 2,
  parameter int RST_TMR   = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          tick_en,
  input  logic          nr_lock,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          smi_req,
  output logic          sys_rst
);
  localparam int TW = WIDE ? 10 : 6;

  logic [1:0] araw_n, sync_n;
  logic sys_rst_n, por_sync_n;
  logic [TW-1:0] tmr_val, cnt_q;
  logic halt_q, smi_en, nr_q, reload_stb, to_clr, first_exp, second_exp;

  assign araw_n = {por_n, rst_n & por_n};

  for (genvar g = 0; g < 2; g++) begin : g_rsync
    wdt_rst_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk    (clk),
      .arst_ni(araw_n[g]),
      .rst_no (sync_n[g])
    );
  end

  assign sys_rst_n  = sync_n[0];
  assign por_sync_n = sync_n[1];

  wdt_regs #(
    .WIDE(WIDE), .TW(TW), .MIN_CNT(MIN_CNT), .RST_TMR(RST_TMR)
  ) u_regs (
    .clk       (clk),
    .rst_ni    (sys_rst_n),
    .por_ni    (por_sync_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .cnt_i     (cnt_q),
    .first_exp (first_exp),
    .second_exp(second_exp),
    .nr_lock   (nr_lock),
    .tmr_o     (tmr_val),
    .halt_o    (halt_q),
    .smi_en_o  (smi_en),
    .nr_o      (nr_q),
    .reload_o  (reload_stb),
    .to_clr_o  (to_clr)
  );

  wdt_core #(.TW(TW), .RST_TMR(RST_TMR)) u_core (
    .clk       (clk),
    .rst_ni    (sys_rst_n),
    .tick      (tick_en),
    .halt      (halt_q),
    .tmr       (tmr_val),
    .reload    (reload_stb),
    .stage_clr (to_clr),
    .smi_en    (smi_en),
    .no_reboot (nr_q),
    .cnt_o     (cnt_q),
    .first_exp (first_exp),
    .second_exp(second_exp),
    .smi_req   (smi_req),
    .sys_rst   (sys_rst)
  );
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int TW = 10
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          smi_req,
  input logic          sys_rst,
  input logic          halt,
  input logic          no_reboot,
  input logic          nr_lock,
  input logic          reload,
  input logic [TW-1:0] cnt
);
  // R6: interrupt request is a single-cycle pulse
  assert_smi_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    smi_req |=> !smi_req);

  // R8: reset request is a single-cycle pulse
  assert_rst_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    sys_rst |=> !sys_rst);

  // R8: the counter is halted whenever the reset pulse is out
  assert_halt_on_rst_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    sys_rst |-> halt);

  // R9: no reset pulse follows a cycle with no-reboot set
  assert_noreboot_blocks_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    sys_rst |-> !$past(no_reboot));

  // R10: lock forces the no-reboot bit
  assert_lock_forces_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    nr_lock |=> no_reboot);

  // R4: halted counter without reload does not move
  assert_halt_stable_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (halt && !reload) |=> $stable(cnt));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_ni   (sys_rst_n),
  .smi_req  (smi_req),
  .sys_rst  (sys_rst),
  .halt     (halt_q),
  .no_reboot(nr_q),
  .nr_lock  (nr_lock),
  .reload   (reload_stb),
  .cnt      (cnt_q)
);

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;
  import wdt_pkg::*;

  logic clk, rst_n, por_n, tick_en, nr_lock, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic smi_req, sys_rst;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  wdt_two_stage dut_i (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_en(tick_en),
    .nr_lock(nr_lock), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smi_req(smi_req), .sys_rst(sys_rst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {addr, write data, expected readback}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {A_TMR,  16'h0000, 16'h0002},   // R2 clamp
    {A_TMR,  16'h0001, 16'h0002},   // R2 clamp
    {A_TMR,  16'h0064, 16'h0064},   // R2
    {A_TMR,  16'hFFFF, 16'h03FF},   // R2 field width
    {A_CTRL, 16'hFFFF, 16'h0A00},   // R3
    {A_CTRL, 16'h0A00, 16'h0A00},   // R3
    {A_CTRL, 16'h0000, 16'h0000},   // R3
    {A_CTRL, 16'h0200, 16'h0200},   // R3
    {A_CTRL, 16'h0800, 16'h0800},   // R3
    {A_CFG,  16'h0003, 16'h0003},
    {A_CFG,  16'hFFFC, 16'h0000},
    {A_TMR,  16'h0005, 16'h0005}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_rst(input bit por);
    @(negedge clk);
    if (por) por_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; por_n = 1'b0; tick_en = 1'b0; nr_lock = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 smi", {15'b0, smi_req}, 16'h0);
    chk("R1 rst", {15'b0, sys_rst}, 16'h0);
    rdchk("R1 tmr",  A_TMR,  16'h0004);
    rdchk("R1 cnt",  A_CNT,  16'h0004);
    rdchk("R1 ctrl", A_CTRL, 16'h0800);
    rdchk("R1 cfg",  A_CFG,  16'h0000);
    rdchk("R1 sts1", A_STS1, 16'h0000);
    rdchk("R1 sts2", A_STS2, 16'h0000);

    // register vectors (R2, R3)
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][34:32], VEC[i][31:16]);
      rdchk("R2/R3 vector", VEC[i][34:32], VEC[i][15:0]);
    end

    // R4/R5 countdown and reload
    wr(A_CNT, 16'h0001);
    rdchk("R5 reload", A_CNT, 16'h0005);
    wr(A_CFG, 16'h0001);
    wr(A_CTRL, 16'h0000);
    ticks(2);
    rdchk("R4 count", A_CNT, 16'h0003);
    wr(A_CNT, 16'h0020);
    rdchk("R5 ignored reload", A_CNT, 16'h0003);
    wr(A_CNT, 16'h0010);
    rdchk("R5 reload bit4", A_CNT, 16'h0005);
    wr(A_CTRL, 16'h0800);
    ticks(3);
    rdchk("R4 halted", A_CNT, 16'h0005);
    wr(A_CTRL, 16'h0000);

    // R6 first expiry
    ticks(5);
    chk("R6 no early smi", {15'b0, smi_req}, 16'h0);
    rdchk("R4 at zero", A_CNT, 16'h0000);
    ticks(1);
    chk("R6 smi", {15'b0, smi_req}, 16'h1);
    chk("R6 no rst", {15'b0, sys_rst}, 16'h0);
    @(negedge clk);
    chk("R6 smi width", {15'b0, smi_req}, 16'h0);
    rdchk("R6 sts", A_STS1, 16'h0008);
    rdchk("R6 reload", A_CNT, 16'h0005);

    // R8 second expiry
    ticks(6);
    chk("R8 rst", {15'b0, sys_rst}, 16'h1);
    @(negedge clk);
    chk("R8 rst width", {15'b0, sys_rst}, 16'h0);
    rdchk("R8 sts2", A_STS2, 16'h0002);
    rdchk("R8 halt", A_CTRL, 16'h0800);
    ticks(3);
    rdchk("R8 frozen", A_CNT, 16'h0005);

    // R12 sticky through system reset
    pulse_rst(1'b0);
    rdchk("R12 sec kept", A_STS2, 16'h0002);
    rdchk("R1 tmr after rst", A_TMR, 16'h0004);
    rdchk("R1 sts1 after rst", A_STS1, 16'h0000);

    // R7/R9 no interrupt, no reboot
    wr(A_CFG, 16'h0002);
    wr(A_CNT, 16'h0001);
    wr(A_CTRL, 16'h0000);
    ticks(5);
    chk("R7 no smi", {15'b0, smi_req}, 16'h0);
    rdchk("R7 sts", A_STS1, 16'h0008);
    ticks(5);
    chk("R9 no rst", {15'b0, sys_rst}, 16'h0);
    @(negedge clk);
    chk("R9 no rst later", {15'b0, sys_rst}, 16'h0);
    rdchk("R9/R12 sec and boot", A_STS2, 16'h0006);

    // R11 write-1-to-clear isolation
    wr(A_STS2, 16'h0002);
    rdchk("R11 clear sec only", A_STS2, 16'h0004);
    wr(A_STS1, 16'h0000);
    rdchk("R11 zero write", A_STS1, 16'h0008);
    wr(A_STS2, 16'h0000);
    rdchk("R11 zero write sts2", A_STS2, 16'h0004);
    wr(A_STS2, 16'h0004);
    rdchk("R11 clear boot", A_STS2, 16'h0000);
    wr(A_STS1, 16'h0008);
    rdchk("R11 clear to", A_STS1, 16'h0000);

    // R13 service between expiries
    wr(A_CFG, 16'h0001);
    wr(A_CNT, 16'h0001);
    wr(A_CTRL, 16'h0000);
    ticks(5);
    chk("R13 first smi", {15'b0, smi_req}, 16'h1);
    wr(A_CNT, 16'h0001);
    ticks(5);
    chk("R13 reload then smi", {15'b0, smi_req}, 16'h1);
    chk("R13 reload no rst", {15'b0, sys_rst}, 16'h0);
    wr(A_STS1, 16'h0008);
    ticks(5);
    chk("R13 clear then smi", {15'b0, smi_req}, 16'h1);
    chk("R13 clear no rst", {15'b0, sys_rst}, 16'h0);
    ticks(5);
    chk("R13 unserviced rst", {15'b0, sys_rst}, 16'h1);

    // R10 lock
    nr_lock = 1'b1;
    wr(A_CFG, 16'h0000);
    rdchk("R10 locked", A_CFG, 16'h0002);
    nr_lock = 1'b0;
    rdchk("R10 after unlock", A_CFG, 16'h0002);
    wr(A_CFG, 16'h0000);
    rdchk("R10 cleared", A_CFG, 16'h0000);

    // R12 power-on clears sticky status
    rdchk("R12 before por", A_STS2, 16'h0002);
    pulse_rst(1'b1);
    rdchk("R12 after por", A_STS2, 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule